// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port reached through a simple memory-mapped register bus. The bus has an address, a write enable, write data and combinational read data. Software drives the output pins through a data register. Two alias addresses let it set or clear selected output bits without a read-modify-write. A per-pin direction register decides which pins the block drives. The pad tristate buffers sit outside the block and use `padOutEn` as their enable.

Each input pin passes through a two-flop synchroniser. The synchronised value appears in the data-in register and feeds a per-pin interrupt detector. The detector can watch for a rising edge, a falling edge, both edges, a high level or a low level. A detected event sets a sticky status bit, which software clears by writing ones. A per-pin mask decides which status bits reach the single registered interrupt output.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads zero, and `padOut`, `padOutEn` and `irqOut` are all low.
- R2: A write to 0x00 loads the output register. A write to 0x10 sets each output bit where the written word has a 1. A write to 0x14 clears each output bit where the word has a 1. Bits written as 0 through 0x10 or 0x14 keep their value. The output register reads back at 0x00 and drives `padOut`.
- R3: The direction register at 0x08 drives `padOutEn`. A bit of 1 makes that pin an output and a bit of 0 makes it an input.
- R4: Data-in at 0x04 shows bit n of `padIn` two clock edges after it changes. After only one edge it still shows the old value.
- R5: Edge mode is selected when the type bit (0x34) is 0. With the both-edges bit (0x38) at 0 and the polarity bit (0x3C) at 0, a synchronised rising edge sets that pin's status bit (0x24). A falling edge does not set it.
- R6: In edge mode with both-edges at 0 and polarity at 1, a falling edge sets the status bit and a rising edge does not.
- R7: In edge mode with the both-edges bit at 1, rising and falling edges both set the status bit.
- R8: Level mode is selected when the type bit is 1. The status bit is set while the synchronised input is high (polarity 0) or low (polarity 1). A clear has no effect while that level persists.
- R9: Writing to 0x30 clears the status bits where the word has a 1 and leaves the other bits alone. A detection on the same cycle as the clear leaves that bit set.
- R10: A pin whose interrupt-enable bit (0x20) is 0 never sets its status bit.
- R11: `irqOut` is a register holding the OR over all pins of status AND NOT mask, where the mask is at 0x2C. A mask bit of 1 keeps that pin off `irqOut`.
- R12: The slots 0x18, 0x1C, 0x40 and 0x44 read zero and ignore writes. Writes to the status register at 0x24 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| busAddr | input | 8 | Byte address of the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| padIn | input | 32 | Pin levels seen at the pads |
| padOut | output | 32 | Output values for the pads |
| padOutEn | output | 32 | Per-pin drive enable for the pad buffers |
| irqOut | output | 1 | Combined interrupt, registered |

## Verification
The assertions assume that `busWrEn` is a single-cycle strobe. They also assume that `padIn` changes only between clock edges, so that the synchroniser and the previous-value flop see clean values. The bench changes pads and bus signals only on falling clock edges and deasserts each write after one cycle. It waits the full synchroniser-plus-detector latency before it reads status. The clear-versus-edge collision is placed on the exact edge where the detector fires.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam logic [7:0] OFF_OUT   = 8'h00;
  localparam logic [7:0] OFF_IN    = 8'h04;
  localparam logic [7:0] OFF_DIR   = 8'h08;
  localparam logic [7:0] OFF_SET   = 8'h10;
  localparam logic [7:0] OFF_CLR   = 8'h14;
  localparam logic [7:0] OFF_EN    = 8'h20;
  localparam logic [7:0] OFF_STAT  = 8'h24;
  localparam logic [7:0] OFF_MASK  = 8'h2C;
  localparam logic [7:0] OFF_ACK   = 8'h30;
  localparam logic [7:0] OFF_TYPE  = 8'h34;
  localparam logic [7:0] OFF_BOTH  = 8'h38;
  localparam logic [7:0] OFF_LEVEL = 8'h3C;

  typedef enum logic [3:0] {
    SelNone, SelOut, SelIn, SelDir, SelEn, SelStat,
    SelMask, SelType, SelBoth, SelLevel
  } rdSel_e;

  typedef struct packed {
    logic wrOut;
    logic setOut;
    logic clrOut;
    logic wrDir;
    logic wrEn;
    logic wrMask;
    logic clrStat;
    logic wrType;
    logic wrBoth;
    logic wrLevel;
  } strobe_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output strobe_t           stb,
  output rdSel_e            rdSel
);
  always_comb begin
    stb   = '0;
    rdSel = SelNone;
    case (busAddr)
      ADDR_W'(OFF_OUT):   begin rdSel = SelOut;   stb.wrOut   = busWrEn; end
      ADDR_W'(OFF_IN):    rdSel = SelIn;
      ADDR_W'(OFF_DIR):   begin rdSel = SelDir;   stb.wrDir   = busWrEn; end
      ADDR_W'(OFF_SET):   stb.setOut = busWrEn;
      ADDR_W'(OFF_CLR):   stb.clrOut = busWrEn;
      ADDR_W'(OFF_EN):    begin rdSel = SelEn;    stb.wrEn    = busWrEn; end
      ADDR_W'(OFF_STAT):  rdSel = SelStat;
      ADDR_W'(OFF_MASK):  begin rdSel = SelMask;  stb.wrMask  = busWrEn; end
      ADDR_W'(OFF_ACK):   stb.clrStat = busWrEn;
      ADDR_W'(OFF_TYPE):  begin rdSel = SelType;  stb.wrType  = busWrEn; end
      ADDR_W'(OFF_BOTH):  begin rdSel = SelBoth;  stb.wrBoth  = busWrEn; end
      ADDR_W'(OFF_LEVEL): begin rdSel = SelLevel; stb.wrLevel = busWrEn; end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  rdSel_e           rdSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOutEn,
  output logic             irqOut
);
  logic [WIDTH-1:0] dataOut, dirReg, intEn, intMask, intType, intBoth, intLevel;
  logic [WIDTH-1:0] intStatus, syncA, syncB, prevIn, hit;

  // Configuration and output registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      dirReg   <= '0;
      intEn    <= '0;
      intMask  <= '0;
      intType  <= '0;
      intBoth  <= '0;
      intLevel <= '0;
    end else begin
      if (stb.wrOut)   dataOut  <= wrData;
      if (stb.setOut)  dataOut  <= dataOut | wrData;
      if (stb.clrOut)  dataOut  <= dataOut & ~wrData;
      if (stb.wrDir)   dirReg   <= wrData;
      if (stb.wrEn)    intEn    <= wrData;
      if (stb.wrMask)  intMask  <= wrData;
      if (stb.wrType)  intType  <= wrData;
      if (stb.wrBoth)  intBoth  <= wrData;
      if (stb.wrLevel) intLevel <= wrData;
    end
  end

  // Two-flop synchroniser plus one-cycle history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevIn <= '0;
    end else begin
      syncA  <= padIn;
      syncB  <= syncA;
      prevIn <= syncB;
    end
  end

  // Per-pin detector
  for (genvar p = 0; p < WIDTH; p++) begin : g_det
    logic rise, fall, edgeHit, levelHit;
    always_comb begin
      rise     = syncB[p] & ~prevIn[p];
      fall     = ~syncB[p] & prevIn[p];
      edgeHit  = intBoth[p] ? (rise | fall) : (intLevel[p] ? fall : rise);
      levelHit = intLevel[p] ? ~syncB[p] : syncB[p];
      hit[p]   = intEn[p] & (intType[p] ? levelHit : edgeHit);
    end
  end

  // Sticky status: a new detection wins over a clear on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStatus <= '0;
      irqOut    <= 1'b0;
    end else begin
      intStatus <= (intStatus & ~(stb.clrStat ? wrData : '0)) | hit;
      irqOut    <= |(intStatus & ~intMask);
    end
  end

  always_comb begin
    case (rdSel)
      SelOut:   rdData = dataOut;
      SelIn:    rdData = syncB;
      SelDir:   rdData = dirReg;
      SelEn:    rdData = intEn;
      SelStat:  rdData = intStatus;
      SelMask:  rdData = intMask;
      SelType:  rdData = intType;
      SelBoth:  rdData = intBoth;
      SelLevel: rdData = intLevel;
      default:  rdData = '0;
    endcase
  end

  assign padOut   = dataOut;
  assign padOutEn = dirReg;

  assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOut |=> ((dataOut & $past(wrData)) == $past(wrData)));
  assert_clr_alias_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrOut |=> ((dataOut & $past(wrData)) == '0));
  assert_hit_sticks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|hit) |=> ((intStatus & $past(hit)) == $past(hit)));
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStat |=> ((intStatus & $past(wrData) & ~$past(hit)) == '0));
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (intEn == '0) |=> ((intStatus & ~$past(intStatus)) == '0));
  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((intStatus & ~intMask) == '0) |=> !irqOut);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOutEn,
  output logic              irqOut
);
  strobe_t stb;
  rdSel_e  rdSel;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .stb(stb), .rdSel(rdSel)
  );

  gpio_port_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .wrData(busWrData),
    .padIn(padIn), .rdData(busRdData), .padOut(padOut),
    .padOutEn(padOutEn), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 32'hA5A5_0000, 8'h00, 32'hA5A5_0000},
    '{8'h10, 32'h0000_00FF, 8'h00, 32'hA5A5_00FF},
    '{8'h14, 32'hA000_000F, 8'h00, 32'h05A5_00F0},
    '{8'h08, 32'hFFFF_0000, 8'h08, 32'hFFFF_0000},
    '{8'h18, 32'hFFFF_FFFF, 8'h18, 32'h0000_0000},
    '{8'h1C, 32'hFFFF_FFFF, 8'h1C, 32'h0000_0000},
    '{8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000},
    '{8'h44, 32'hFFFF_FFFF, 8'h44, 32'h0000_0000},
    '{8'h24, 32'hFFFF_FFFF, 8'h24, 32'h0000_0000},
    '{8'h2C, 32'h0000_00F0, 8'h2C, 32'h0000_00F0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOutEn;
  logic        irqOut;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOutEn(padOutEn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic setPin(input int idx, input logic val);
    @(negedge clk);
    padIn[idx] = val;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    readCheck("R1 out", 8'h00, 32'h0);
    readCheck("R1 dir", 8'h08, 32'h0);
    readCheck("R1 en", 8'h20, 32'h0);
    readCheck("R1 stat", 8'h24, 32'h0);
    check("R1 padOut", padOut, 32'h0);
    check("R1 padOutEn", padOutEn, 32'h0);
    check("R1 irqOut", {31'b0, irqOut}, 32'h0);

    // R4 synchroniser latency
    @(negedge clk) padIn = 32'h1234_0000;
    readCheck("R4 one edge", 8'h04, 32'h0);
    readCheck("R4 two edges", 8'h04, 32'h1234_0000);
    @(negedge clk) padIn = 32'h0;
    repeat (3) @(posedge clk);

    // Table: R2 R3 R12
    for (int i = 0; i < NVEC; i++) begin
      busWrite(VECS[i].wa, VECS[i].wd);
      busRead(VECS[i].ra, v);
      checks++;
      if (v !== VECS[i].exp) begin
        fails++;
        $display("FAIL R2/R3/R12 entry %0d: actual %08h expected %08h", i, v, VECS[i].exp);
      end
    end
    check("R2 padOut", padOut, 32'h05A5_00F0);
    check("R3 padOutEn", padOutEn, 32'hFFFF_0000);

    // Interrupt setup: pin0 rise, 1 fall, 2 both, 3 high, 4 low, 5 disabled
    setPin(4, 1'b1);
    busWrite(8'h2C, 32'h0);
    busWrite(8'h34, 32'h18);
    busWrite(8'h38, 32'h04);
    busWrite(8'h3C, 32'h12);
    busWrite(8'h20, 32'h1F);
    busWrite(8'h30, 32'hFFFF_FFFF);
    readCheck("R9 clear all", 8'h24, 32'h0);

    setPin(0, 1'b1);
    readCheck("R5 rising", 8'h24, 32'h1);
    check("R11 irq set", {31'b0, irqOut}, 32'h1);
    busWrite(8'h30, 32'h1);
    readCheck("R9 clear", 8'h24, 32'h0);
    @(negedge clk);
    check("R11 irq drop", {31'b0, irqOut}, 32'h0);
    setPin(0, 1'b0);
    readCheck("R5 falling ignored", 8'h24, 32'h0);

    setPin(1, 1'b1);
    readCheck("R6 rising ignored", 8'h24, 32'h0);
    setPin(1, 1'b0);
    readCheck("R6 falling", 8'h24, 32'h2);
    busWrite(8'h30, 32'h2);

    setPin(2, 1'b1);
    readCheck("R7 rise", 8'h24, 32'h4);
    busWrite(8'h30, 32'h4);
    setPin(2, 1'b0);
    readCheck("R7 fall", 8'h24, 32'h4);
    busWrite(8'h30, 32'h4);

    setPin(5, 1'b1);
    readCheck("R10 disabled", 8'h24, 32'h0);

    setPin(3, 1'b1);
    readCheck("R8 high", 8'h24, 32'h8);
    busWrite(8'h30, 32'h8);
    readCheck("R8 high held", 8'h24, 32'h8);
    setPin(3, 1'b0);
    busWrite(8'h30, 32'h8);
    readCheck("R8 high released", 8'h24, 32'h0);

    setPin(4, 1'b0);
    readCheck("R8 low", 8'h24, 32'h10);
    busWrite(8'h30, 32'h10);
    readCheck("R8 low held", 8'h24, 32'h10);
    setPin(4, 1'b1);
    busWrite(8'h30, 32'h10);
    readCheck("R8 low released", 8'h24, 32'h0);

    // R11 masking
    busWrite(8'h2C, 32'h1);
    setPin(0, 1'b1);
    readCheck("R11 masked stat", 8'h24, 32'h1);
    check("R11 masked irq", {31'b0, irqOut}, 32'h0);
    busWrite(8'h2C, 32'h0);
    @(negedge clk);
    check("R11 unmasked irq", {31'b0, irqOut}, 32'h1);

    // R9 partial clear and edge-beats-clear
    setPin(2, 1'b1);
    readCheck("R9 two set", 8'h24, 32'h5);
    busWrite(8'h30, 32'h1);
    readCheck("R9 zero bits kept", 8'h24, 32'h4);
    @(negedge clk) padIn[2] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    busWrite(8'h30, 32'h4);
    readCheck("R9 edge wins", 8'h24, 32'h4);
    busWrite(8'h30, 32'h4);
    readCheck("R9 later clear", 8'h24, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule